// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank Controller

This block runs one bank of general-purpose pins. Software reaches it through a small window of word-spaced registers on a simple synchronous bus. The bus has an enable, a write strobe, a byte address and one data word each way. Read data comes back in the same cycle. Through these registers each pin gets a direction and a driven value. A pin can also be handed to an external peripheral signal, or forced to a preset level while the bank sleeps or while the battery-fault input is high.

Every input is passed through a flop synchroniser. The synchronised level can then raise an interrupt on a high level, a low level, a rising edge or a falling edge, chosen per pin. Detected events collect in a sticky status register that software clears by writing 1s. The unmasked status bits are ORed into one interrupt line. A second mask set takes over while the bank is asleep.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, every writable register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: Registers sit at byte offset 4*k, and the word index k is `bus_addr[5:2]`. The map is: 0 interrupt mask, 1 direction, 2 output data, 3 detect mode, 4 edge polarity, 5 level polarity, 6 sleep mask, 7 sleep level, 8 fault level, 9 event status, 10 peripheral select, 11 sleep control (2 bits), 12 pin levels. Each writable register reads back what was last written to it. The sleep control register keeps only bits [1:0]. Indices 13 to 15 read 0.
- R3: `pin_oe[i]` equals direction bit i (1 = output). With no override active, `pin_out[i]` equals output-data bit i.
- R4: Index 12 is read-only and returns `pin_in` delayed by two synchroniser flops. A change is visible after the second rising edge. Writes to index 12 have no effect.
- R5: A detect-mode bit of 0 selects level detection. The level-polarity bit then picks the active level (1 high, 0 low). The status bit is set on the edge after the synchronised level is active, and a clear has no effect while that level persists.
- R6: A detect-mode bit of 1 selects edge detection. The edge-polarity bit picks the edge (1 rising, 0 falling). The status bit sets on the third rising edge after `pin_in` changes. An event on the same edge as a clear of that bit wins, and the bit stays 1.
- R7: Status bits are sticky. Writing 1 to a bit of index 9 clears it, and writing 0 leaves it unchanged.
- R8: `irq` is 1 when any status bit is set whose active mask bit is 0. A mask bit of 1 blocks that pin. In the default variant `irq` follows status combinationally.
- R9: The bank is asleep when `sleep_req` is 1 and sleep-control bit 1 (autosleep) is 1. While asleep, the sleep mask replaces the interrupt mask and `pin_out` takes the sleep-level register. Sleep-control bit 0 forces the sleep levels onto `pin_out` while awake too.
- R10: While `batt_fault` is 1, `pin_out` equals the fault-level register. This overrides sleep, peripheral and data values.
- R11: A peripheral-select bit of 1 routes `alt_in[i]` to `pin_out[i]` in place of the output-data bit. Sleep and fault levels still take priority.
- R12: `irq` stays 0 from reset until the first register write, even when status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the bank |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle, 0 when idle |
| pin_in | input | 16 | Raw pin levels |
| alt_in | input | 16 | Peripheral-driven pin values |
| sleep_req | input | 1 | Sleep request from power control |
| batt_fault | input | 1 | Battery-fault condition |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Combined bank interrupt |

## Verification
Register writes take effect on the edge that commits them. Readback, `pin_oe` and `pin_out` are therefore due one edge after the write, and `irq` is due on the same edge as the status change. A pin change appears in the pin-level register after two rising edges, and it sets a status bit on the third. The bench counts edges exactly around that point: it checks that the bit is still 0 after two edges and is 1 after three. All inputs are driven at the falling edge and outputs are read just after it. The clear-versus-event case lines up a status write with the third edge after a pin change.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   // word indices within the bank window (byte offset = 4 * index)
   localparam int unsigned OFS_MASK  = 0;
   localparam int unsigned OFS_DIR   = 1;
   localparam int unsigned OFS_OUT   = 2;
   localparam int unsigned OFS_TRIG  = 3;
   localparam int unsigned OFS_EDGE  = 4;
   localparam int unsigned OFS_LVL   = 5;
   localparam int unsigned OFS_SMASK = 6;
   localparam int unsigned OFS_SOUT  = 7;
   localparam int unsigned OFS_BOUT  = 8;
   localparam int unsigned OFS_STAT  = 9;
   localparam int unsigned OFS_ALT   = 10;
   localparam int unsigned OFS_SCFG  = 11;
   localparam int unsigned OFS_PINS  = 12;
   // sleep control fields
   localparam int unsigned SCFG_FORCE_BIT = 0;
   localparam int unsigned SCFG_AUTO_BIT  = 1;
   localparam int unsigned SCFG_W         = 2;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int N      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout,
   output logic [N-1:0] dprev
);
   // STAGES synchroniser flops plus one history flop for edge detection
   logic [STAGES:0][N-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign dout  = chain[STAGES-1];
   assign dprev = chain[STAGES];
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] prv,
   input  logic [N-1:0] trig_edge,
   input  logic [N-1:0] edge_rise,
   input  logic [N-1:0] lvl_high,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status
);
   logic [N-1:0] evt;

   for (genvar i = 0; i < N; i++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      assign rise     = lvl[i] & ~prv[i];
      assign fall     = ~lvl[i] & prv[i];
      assign lvl_hit  = (lvl[i] == lvl_high[i]);
      assign edge_hit = edge_rise[i] ? rise : fall;
      assign evt[i]   = trig_edge[i] ? edge_hit : lvl_hit;
   end

   // new events win over a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | evt;
   end
endmodule

// File: rtl/gpb_drive.sv
module gpb_drive #(
   parameter int N = 16
) (
   input  logic [N-1:0] dir,
   input  logic [N-1:0] dout,
   input  logic [N-1:0] alt_sel,
   input  logic [N-1:0] alt_in,
   input  logic [N-1:0] sleep_lvl,
   input  logic [N-1:0] fault_lvl,
   input  logic         sleep_drive,
   input  logic         fault,
   output logic [N-1:0] pin_out,
   output logic [N-1:0] pin_oe
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      logic normal_v;
      assign normal_v   = alt_sel[i] ? alt_in[i] : dout[i];
      assign pin_out[i] = fault       ? fault_lvl[i] :
                          sleep_drive ? sleep_lvl[i] : normal_v;
      assign pin_oe[i]  = dir[i];
   end
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
   import gpb_pkg::*;
#(
   parameter int N_PINS      = 16,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_PINS-1:0] pin_in,
   input  logic [N_PINS-1:0] alt_in,
   input  logic              sleep_req,
   input  logic              batt_fault,
   output logic [N_PINS-1:0] pin_out,
   output logic [N_PINS-1:0] pin_oe,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (N_PINS > DATA_W) begin : g_bad_width
      $error("N_PINS must not exceed DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IDX_W < 4) begin : g_bad_addr
      $error("ADDR_W must decode 13 word registers");
   end

   logic [IDX_W-1:0] idx;
   logic             wr;
   logic             unused_ok;
   assign idx       = bus_addr[ADDR_W-1:2];
   assign wr        = bus_en & bus_we;
   assign unused_ok = ^bus_addr[1:0];

   logic [N_PINS-1:0] r_mask, r_dir, r_out, r_trig, r_edge, r_lvl;
   logic [N_PINS-1:0] r_smask, r_sout, r_bout, r_alt;
   logic [SCFG_W-1:0] r_scfg;
   logic              armed;
   logic [N_PINS-1:0] wv;
   assign wv = bus_wdata[N_PINS-1:0];

   function automatic logic hit(input logic [IDX_W-1:0] a, input int unsigned k);
      return a == IDX_W'(k);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_mask <= '0; r_dir <= '0; r_out <= '0; r_trig <= '0;
         r_edge <= '0; r_lvl <= '0; r_smask <= '0; r_sout <= '0;
         r_bout <= '0; r_alt <= '0; r_scfg <= '0; armed <= 1'b0;
      end else if (wr) begin
         armed <= 1'b1;
         if (hit(idx, OFS_MASK))  r_mask  <= wv;
         if (hit(idx, OFS_DIR))   r_dir   <= wv;
         if (hit(idx, OFS_OUT))   r_out   <= wv;
         if (hit(idx, OFS_TRIG))  r_trig  <= wv;
         if (hit(idx, OFS_EDGE))  r_edge  <= wv;
         if (hit(idx, OFS_LVL))   r_lvl   <= wv;
         if (hit(idx, OFS_SMASK)) r_smask <= wv;
         if (hit(idx, OFS_SOUT))  r_sout  <= wv;
         if (hit(idx, OFS_BOUT))  r_bout  <= wv;
         if (hit(idx, OFS_ALT))   r_alt   <= wv;
         if (hit(idx, OFS_SCFG))  r_scfg  <= bus_wdata[SCFG_W-1:0];
      end
   end

   // input path
   logic [N_PINS-1:0] s_lvl, s_prv, st_q, st_clr;
   gpb_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(s_lvl), .dprev(s_prv)
   );

   assign st_clr = (wr && hit(idx, OFS_STAT)) ? wv : '0;

   gpb_detect #(.N(N_PINS)) u_det (
      .clk(clk), .rst_n(rst_n), .lvl(s_lvl), .prv(s_prv),
      .trig_edge(r_trig), .edge_rise(r_edge), .lvl_high(r_lvl),
      .clr(st_clr), .status(st_q)
   );

   // power state and output path
   logic asleep, sleep_drive;
   assign asleep      = sleep_req & r_scfg[SCFG_AUTO_BIT];
   assign sleep_drive = asleep | r_scfg[SCFG_FORCE_BIT];

   gpb_drive #(.N(N_PINS)) u_drv (
      .dir(r_dir), .dout(r_out), .alt_sel(r_alt), .alt_in(alt_in),
      .sleep_lvl(r_sout), .fault_lvl(r_bout), .sleep_drive(sleep_drive),
      .fault(batt_fault), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // interrupt
   logic [N_PINS-1:0] eff_mask;
   logic              irq_c;
   assign eff_mask = asleep ? r_smask : r_mask;
   assign irq_c    = armed & (|(st_q & ~eff_mask));

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   // readback
   logic [N_PINS-1:0] rd_v;
   always_comb begin
      rd_v = '0;
      if      (hit(idx, OFS_MASK))  rd_v = r_mask;
      else if (hit(idx, OFS_DIR))   rd_v = r_dir;
      else if (hit(idx, OFS_OUT))   rd_v = r_out;
      else if (hit(idx, OFS_TRIG))  rd_v = r_trig;
      else if (hit(idx, OFS_EDGE))  rd_v = r_edge;
      else if (hit(idx, OFS_LVL))   rd_v = r_lvl;
      else if (hit(idx, OFS_SMASK)) rd_v = r_smask;
      else if (hit(idx, OFS_SOUT))  rd_v = r_sout;
      else if (hit(idx, OFS_BOUT))  rd_v = r_bout;
      else if (hit(idx, OFS_STAT))  rd_v = st_q;
      else if (hit(idx, OFS_ALT))   rd_v = r_alt;
      else if (hit(idx, OFS_SCFG))  rd_v = N_PINS'(r_scfg);
      else if (hit(idx, OFS_PINS))  rd_v = s_lvl;
   end
   assign bus_rdata = bus_en ? DATA_W'(rd_v) : '0;
endmodule

// File: rtl/gpio_bank_ctl_chk.sv
module gpio_bank_ctl_chk #(
   parameter int N_PINS  = 16,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              batt_fault,
   input logic [N_PINS-1:0] pin_out,
   input logic [N_PINS-1:0] pin_oe,
   input logic              irq,
   input logic [N_PINS-1:0] status
);
   logic             wr, seen_wr, wr_stat, wr_dir, wr_bout;
   logic [ADDR_W-3:0] widx;
   assign widx    = bus_addr[ADDR_W-1:2];
   assign wr      = bus_en & bus_we;
   assign wr_stat = wr && widx == (ADDR_W-2)'(9);
   assign wr_dir  = wr && widx == (ADDR_W-2)'(1);
   assign wr_bout = wr && widx == (ADDR_W-2)'(8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  seen_wr <= 1'b0;
      else if (wr) seen_wr <= 1'b1;
   end

   // R12
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_wr |-> !irq);

   // R7
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((status & $past(status)) == $past(status)));

   // R3
   dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (pin_oe == $past(bus_wdata[N_PINS-1:0])));

   // R10
   fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bout && batt_fault) |=> (!batt_fault || pin_out == $past(bus_wdata[N_PINS-1:0])));

   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && irq) |-> (|status));
endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(
   .N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .batt_fault(batt_fault),
   .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .status(st_q)
);

// File: tb/gpio_bank_ctl_bench.sv
module gpio_bank_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in = '0, alt_in = '0;
   logic        sleep_req = 1'b0, batt_fault = 1'b0;
   logic [15:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_bank_ctl u_gpio_bank_ctl (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .alt_in(alt_in), .sleep_req(sleep_req),
      .batt_fault(batt_fault), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a falling edge; commits on the next rising edge
   task automatic wr(input int k, input logic [15:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'(k * 4); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int k, output logic [15:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'(k * 4);
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d, pat, base, act;
      pin_in = '0;
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      for (int k = 0; k < 12; k++) begin
         if (k != 9) begin rd(k, d); chk("R1 reg reset", d, 0); end
      end
      chk("R1 pin_oe reset", pin_oe, 0);
      chk("R1 pin_out reset", pin_out, 0);
      chk("R1 irq reset", irq, 0);
      // R12 level-low on idle pins set status, interrupt still gated
      rd(9, d); chk("R12 status latched", d, 16'hFFFF);
      chk("R12 irq gated", irq, 0);

      // R2 readback sweep
      for (int k = 0; k < 12; k++) begin
         if (k != 9) begin
            pat = 16'(k * 16'h1111) ^ 16'hA5C3;
            wr(k, pat);
            rd(k, d);
            chk("R2 readback", d, (k == 11) ? (pat & 16'h3) : pat);
         end
      end
      for (int k = 13; k < 16; k++) begin rd(k, d); chk("R2 unmapped", d, 0); end
      for (int k = 0; k < 12; k++) if (k != 9) wr(k, 16'h0000);

      // R4 pin levels through two flops, read-only
      pin_in = 16'h3C5A;
      tick(1); rd(12, d); chk("R4 not yet", d, 16'h0000);
      tick(1); rd(12, d); chk("R4 synced", d, 16'h3C5A);
      wr(12, 16'hFFFF); rd(12, d); chk("R4 write ignored", d, 16'h3C5A);
      pin_in = '0; tick(3);

      // R3 direction and data
      wr(1, 16'hF0F0); wr(2, 16'h1234);
      chk("R3 pin_oe", pin_oe, 16'hF0F0);
      chk("R3 pin_out", pin_out, 16'h1234);
      // R11 peripheral select
      alt_in = 16'h5A5A; wr(10, 16'h00FF);
      chk("R11 alt mux", pin_out, (16'h00FF & 16'h5A5A) | (16'hFF00 & 16'h1234));
      // R9 sleep levels
      wr(7, 16'hBEEF); sleep_req = 1'b1; #1;
      chk("R9 no autosleep", pin_out, 16'h125A);
      wr(11, 16'h0002);
      chk("R9 asleep levels", pin_out, 16'hBEEF);
      sleep_req = 1'b0; #1;
      chk("R9 awake again", pin_out, 16'h125A);
      wr(11, 16'h0001);
      chk("R9 forced levels", pin_out, 16'hBEEF);
      // R10 fault overrides all
      wr(8, 16'h0F0F); wr(11, 16'h0002); sleep_req = 1'b1; batt_fault = 1'b1; #1;
      chk("R10 fault level", pin_out, 16'h0F0F);
      batt_fault = 1'b0; sleep_req = 1'b0;
      for (int k = 0; k < 12; k++) if (k != 9) wr(k, 16'h0000);

      // R5 R6 R7 R8 detection sweep over every pin and mode
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 16; p++) begin
            base = (m == 0 || m == 3) ? 16'hFFFF : 16'h0000;
            act  = base ^ (16'h1 << p);
            pin_in = base;
            wr(3, (m >= 2) ? 16'hFFFF : 16'h0000);
            wr(4, (m == 2) ? 16'hFFFF : 16'h0000);
            wr(5, (m == 1) ? 16'hFFFF : 16'h0000);
            wr(0, ~(16'h1 << p));
            tick(3);
            wr(9, 16'hFFFF);
            rd(9, d); chk("R7 cleared", d, 0);
            chk("R8 irq idle", irq, 0);
            pin_in = act;
            tick(2); rd(9, d); chk("R6 R5 not before third edge", d[p], 0);
            tick(1); rd(9, d); chk("R5 R6 event", d[p], 1);
            chk("R8 irq raised", irq, 1);
            wr(0, 16'hFFFF); chk("R8 irq masked", irq, 0);
            wr(0, ~(16'h1 << p));
            if (m >= 2) begin
               pin_in = base; tick(3);
               wr(9, 16'h0000); rd(9, d); chk("R7 zero write no effect", d[p], 1);
               wr(9, 16'h1 << p); rd(9, d); chk("R7 w1c", d[p], 0);
               chk("R8 irq dropped", irq, 0);
            end else begin
               wr(9, 16'h1 << p); rd(9, d); chk("R5 held while active", d[p], 1);
               pin_in = base; tick(3);
               wr(9, 16'h1 << p); rd(9, d); chk("R5 clear after release", d[p], 0);
            end
         end
      end

      // R6 event coinciding with clear wins
      pin_in = '0; wr(3, 16'hFFFF); wr(4, 16'hFFFF); wr(0, 16'h0000);
      tick(3); wr(9, 16'hFFFF);
      pin_in = 16'h0001; tick(3);
      pin_in = 16'h0000; tick(3);
      rd(9, d); chk("R6 set before race", d[0], 1);
      pin_in = 16'h0001;
      tick(2);
      wr(9, 16'h0001);
      rd(9, d); chk("R6 event beats clear", d[0], 1);
      wr(9, 16'h0001); rd(9, d); chk("R6 plain clear", d[0], 0);

      // R9 sleep mask replaces interrupt mask
      wr(3, 16'h0000); wr(5, 16'hFFFF); pin_in = 16'h0008;
      wr(0, 16'hFFF7); wr(6, 16'hFFFF); tick(3);
      wr(9, 16'hFFFF);
      chk("R9 awake irq", irq, 1);
      wr(11, 16'h0002); sleep_req = 1'b1; #1;
      chk("R9 sleep mask blocks", irq, 0);
      sleep_req = 1'b0; #1;
      chk("R9 wake irq", irq, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule